// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides which operating mode a small processor core runs in, and it drives the clock, regulator and power-switch controls for that mode. There are seven modes: full-speed run, low-power run, wait, low-power wait, and three stop depths called stop4 (shallowest), stop3 and stop2 (deepest). The block reads the configuration bits of the system and power-management registers as plain inputs. It also takes a STOP request and a WAIT request from the core and a wakeup input that carries an interrupt or reset event.

When the core requests STOP, the block picks a depth from the configuration that is live in the request cycle. The debug enable, low-voltage detection in stop, and the deep-stop request can each hold the core in stop4. Otherwise the partial power-down request chooses between stop2 and stop3. The debug enable is captured at entry, so later register writes cannot change the active mode or its outputs. A STOP while stopping is disabled does not stop the core. Instead it raises a one-cycle illegal-opcode reset or illegal-instruction exception. On wakeup the clock enables of the mode being returned to come back one cycle before the mode status changes to that mode.

Top module: `pmode_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) the mode is run. mode_oh encodes the mode as one-hot: bit0 run, bit1 low-power run, bit2 wait, bit3 low-power wait, bit4 stop4, bit5 stop3, bit6 stop2. In run, cpu_clk_en, per_clk_en and pwr_sw_on are 1, per_clk_slow and reg_loose are 0, and dbg_clk_en follows dbg_en.
- R2: A stop_req in run or low-power run with stop_en low leaves the mode unchanged. In the next cycle it pulses ill_reset for one cycle if ill_rst_dis is 0, or ill_exc if ill_rst_dis is 1. The two pulses are never high together.
- R3: An accepted stop_req (stop_en high) enters stop4 when dbg_en is 1, or when lvd_en and lvd_stop_en are both 1, or when deep_req is 0. Otherwise it enters stop2 if ppd_req is 1 and stop3 if ppd_req is 0. stop_req takes priority over wait_req.
- R4: In stop2 every clock enable is 0, reg_loose is 0 and pwr_sw_on is 0.
- R5: In stop3 every clock enable is 0, reg_loose is 1 and pwr_sw_on is 1.
- R6: In stop4, per_clk_en is 0. cpu_clk_en and dbg_clk_en equal the dbg_en value held at entry.
- R7: From run, the mode moves to low-power run when lp_reg is 1 and lvd_en is 0, and it moves back when either condition fails. Low-power run has both clocks on, per_clk_slow at 1, reg_loose at 1 and dbg_clk_en following dbg_en.
- R8: wait_req enters wait from run, or low-power wait from low-power run. Wait keeps peripherals on at full speed, with cpu_clk_en and dbg_clk_en equal to the held dbg_en. Low-power wait has cpu_clk_en at 0, peripherals on and slow, and reg_loose at 1.
- R9: After entry into a wait or stop mode, changes to the configuration inputs or new requests change neither the mode nor the outputs until wakeup.
- R10: A wake in a wait or stop mode gives, in the next cycle, the output enables of the mode the core entered from, while mode_oh still shows the low-power mode. In the cycle after that, mode_oh shows the mode the core entered from.
- R11: mode_oh has exactly one bit set in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_en | input | 1 | STOP allowed |
| ill_rst_dis | input | 1 | Illegal STOP raises exception instead of reset |
| dbg_en | input | 1 | Debug enable |
| lvd_en | input | 1 | Low-voltage detection enable |
| lvd_stop_en | input | 1 | Low-voltage detection kept active in stop |
| lp_reg | input | 1 | Low-power regulation request |
| deep_req | input | 1 | Low-power stop requested |
| ppd_req | input | 1 | Partial power-down requested |
| stop_req | input | 1 | Core executes STOP |
| wait_req | input | 1 | Core executes WAIT |
| wake | input | 1 | Interrupt or reset wakeup |
| mode_oh | output | 7 | One-hot mode status |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| per_clk_slow | output | 1 | Clocks at low frequency |
| dbg_clk_en | output | 1 | Debug clock enable |
| reg_loose | output | 1 | Regulator in loose regulation |
| pwr_sw_on | output | 1 | Switched power domain on |
| ill_reset | output | 1 | Illegal-opcode reset pulse |
| ill_exc | output | 1 | Illegal-instruction exception pulse |

## Verification
Two collisions matter. The first is a STOP or WAIT request in the same cycle that the low-power-run entry or exit condition holds: the request must win, and the origin recorded must be the mode current in that cycle. The second is a wake arriving together with fresh requests and configuration changes while the core is in a low-power mode: only the wake may act. Random stimulus makes both happen many times, and a bench reference model built from the requirements decides the expected mode, enables and pulses for every cycle.

// File: rtl/pmode_pkg.sv
// Shared types for the low-power mode sequencer.
// Assumes: the mode code is one-hot, and the bit order is visible at mode_oh.
package pmode_pkg;
    localparam int NMODE = 7;

    typedef enum logic [NMODE-1:0] {
        M_RUN    = 7'b0000001,
        M_LPRUN  = 7'b0000010,
        M_WAIT   = 7'b0000100,
        M_LPWAIT = 7'b0001000,
        M_STOP4  = 7'b0010000,
        M_STOP3  = 7'b0100000,
        M_STOP2  = 7'b1000000
    } mode_e;

    typedef struct packed {
        logic cpu;
        logic per;
        logic slow;
        logic dbg;
        logic loose;
        logic pwr;
    } gate_t;
endpackage

// File: rtl/pmode_stop_sel.sv
// Picks the stop depth for a STOP request from the live configuration.
// Assumes: the caller samples the result only in the cycle the request is accepted.
module pmode_stop_sel
    import pmode_pkg::*;
(
    input  logic  dbg_en,
    input  logic  lvd_en,
    input  logic  lvd_stop_en,
    input  logic  deep_req,
    input  logic  ppd_req,
    output mode_e stop_tgt
);
    logic keep_shallow;

    // Debug, active low-voltage detect, or no deep request all force stop4.
    always_comb begin
        keep_shallow = dbg_en | (lvd_en & lvd_stop_en) | ~deep_req;
        if (keep_shallow)
            stop_tgt = M_STOP4;
        else if (ppd_req)
            stop_tgt = M_STOP2;
        else
            stop_tgt = M_STOP3;
    end
endmodule

// File: rtl/pmode_seq.sv
// Mode state machine: accepts requests, holds the entry configuration,
// flags illegal STOP and sequences the wakeup through a one-cycle resume step.
// Assumes: synchronous active-low reset; requests are honoured only in run or low-power run.
module pmode_seq
    import pmode_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  stop_en,
    input  logic  ill_rst_dis,
    input  logic  dbg_en,
    input  logic  lvd_en,
    input  logic  lp_reg,
    input  logic  stop_req,
    input  logic  wait_req,
    input  logic  wake,
    input  mode_e stop_tgt,
    output mode_e mode_q,
    output mode_e origin_q,
    output logic  resume_q,
    output logic  dbg_hold_q,
    output logic  ill_reset_q,
    output logic  ill_exc_q
);
    mode_e mode_d, origin_d;
    logic  resume_d, hold_d, ir_d, ie_d, active;

    // Next-state decision for mode, origin, held debug and illegal pulses.
    always_comb begin
        active   = (mode_q == M_RUN) || (mode_q == M_LPRUN);
        mode_d   = mode_q;
        origin_d = origin_q;
        hold_d   = dbg_hold_q;
        resume_d = 1'b0;
        ir_d     = 1'b0;
        ie_d     = 1'b0;
        if (resume_q) begin
            mode_d = origin_q;
        end else if (active) begin
            if (stop_req) begin
                if (!stop_en) begin
                    ir_d = ~ill_rst_dis;
                    ie_d = ill_rst_dis;
                end else begin
                    origin_d = mode_q;
                    hold_d   = dbg_en;
                    mode_d   = stop_tgt;
                end
            end else if (wait_req) begin
                origin_d = mode_q;
                hold_d   = dbg_en;
                mode_d   = (mode_q == M_RUN) ? M_WAIT : M_LPWAIT;
            end else if (mode_q == M_RUN && lp_reg && !lvd_en) begin
                mode_d = M_LPRUN;
            end else if (mode_q == M_LPRUN && (!lp_reg || lvd_en)) begin
                mode_d = M_RUN;
            end
        end else if (wake) begin
            resume_d = 1'b1;
        end
    end

    // State registers with synchronous reset to run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q      <= M_RUN;
            origin_q    <= M_RUN;
            resume_q    <= 1'b0;
            dbg_hold_q  <= 1'b0;
            ill_reset_q <= 1'b0;
            ill_exc_q   <= 1'b0;
        end else begin
            mode_q      <= mode_d;
            origin_q    <= origin_d;
            resume_q    <= resume_d;
            dbg_hold_q  <= hold_d;
            ill_reset_q <= ir_d;
            ill_exc_q   <= ie_d;
        end
    end

    AST_ILL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ill_reset_q && ill_exc_q)); // R2
    AST_ILL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (ill_reset_q || ill_exc_q) |-> (mode_q == M_RUN || mode_q == M_LPRUN)); // R2
    AST_STOP2_NODBG: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_STOP2) |-> !dbg_hold_q); // R4
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != M_RUN && mode_q != M_LPRUN && !resume_q && $past(rst_n)
         && $past(mode_q) == mode_q) |-> $stable(dbg_hold_q)); // R9
    AST_RESUME_RET: assert property (@(posedge clk) disable iff (!rst_n)
        resume_q |=> (mode_q == M_RUN || mode_q == M_LPRUN)); // R10
endmodule

// File: rtl/pmode_gate.sv
// Maps the shown mode (or the origin during resume) to the output enables.
// Assumes: the held debug bit is valid in wait and stop modes; run modes use the live bit.
module pmode_gate
    import pmode_pkg::*;
(
    input  mode_e mode_q,
    input  mode_e origin_q,
    input  logic  resume_q,
    input  logic  dbg_hold,
    input  logic  dbg_live,
    output gate_t gates
);
    mode_e eff;

    // Select the effective mode and decode its enable set.
    always_comb begin
        eff   = resume_q ? origin_q : mode_q;
        gates = '0;
        unique case (eff)
            M_RUN:    gates = '{cpu:1'b1, per:1'b1, slow:1'b0, dbg:dbg_live, loose:1'b0, pwr:1'b1};
            M_LPRUN:  gates = '{cpu:1'b1, per:1'b1, slow:1'b1, dbg:dbg_live, loose:1'b1, pwr:1'b1};
            M_WAIT:   gates = '{cpu:dbg_hold, per:1'b1, slow:1'b0, dbg:dbg_hold, loose:1'b0, pwr:1'b1};
            M_LPWAIT: gates = '{cpu:1'b0, per:1'b1, slow:1'b1, dbg:dbg_hold, loose:1'b1, pwr:1'b1};
            M_STOP4:  gates = '{cpu:dbg_hold, per:1'b0, slow:1'b0, dbg:dbg_hold, loose:1'b0, pwr:1'b1};
            M_STOP3:  gates = '{cpu:1'b0, per:1'b0, slow:1'b0, dbg:1'b0, loose:1'b1, pwr:1'b1};
            M_STOP2:  gates = '{cpu:1'b0, per:1'b0, slow:1'b0, dbg:1'b0, loose:1'b0, pwr:1'b0};
            default:  gates = '0;
        endcase
    end
endmodule

// File: rtl/pmode_ctrl.sv
// Top of the low-power mode sequencer: stop-depth selection, mode state
// machine and enable decode. Assumes all control bits are synchronous to clk.
module pmode_ctrl
    import pmode_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_en,
    input  logic             ill_rst_dis,
    input  logic             dbg_en,
    input  logic             lvd_en,
    input  logic             lvd_stop_en,
    input  logic             lp_reg,
    input  logic             deep_req,
    input  logic             ppd_req,
    input  logic             stop_req,
    input  logic             wait_req,
    input  logic             wake,
    output logic [NMODE-1:0] mode_oh,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             per_clk_slow,
    output logic             dbg_clk_en,
    output logic             reg_loose,
    output logic             pwr_sw_on,
    output logic             ill_reset,
    output logic             ill_exc
);
    mode_e stop_tgt, mode_q, origin_q;
    logic  resume_q, dbg_hold_q;
    gate_t gates;

    pmode_stop_sel u_sel (
        .dbg_en(dbg_en), .lvd_en(lvd_en), .lvd_stop_en(lvd_stop_en),
        .deep_req(deep_req), .ppd_req(ppd_req), .stop_tgt(stop_tgt)
    );

    pmode_seq u_seq (
        .clk(clk), .rst_n(rst_n), .stop_en(stop_en), .ill_rst_dis(ill_rst_dis),
        .dbg_en(dbg_en), .lvd_en(lvd_en), .lp_reg(lp_reg),
        .stop_req(stop_req), .wait_req(wait_req), .wake(wake),
        .stop_tgt(stop_tgt), .mode_q(mode_q), .origin_q(origin_q),
        .resume_q(resume_q), .dbg_hold_q(dbg_hold_q),
        .ill_reset_q(ill_reset), .ill_exc_q(ill_exc)
    );

    pmode_gate u_gate (
        .mode_q(mode_q), .origin_q(origin_q), .resume_q(resume_q),
        .dbg_hold(dbg_hold_q), .dbg_live(dbg_en), .gates(gates)
    );

    // Drive the port-level status and enables.
    always_comb begin
        mode_oh      = mode_q;
        cpu_clk_en   = gates.cpu;
        per_clk_en   = gates.per;
        per_clk_slow = gates.slow;
        dbg_clk_en   = gates.dbg;
        reg_loose    = gates.loose;
        pwr_sw_on    = gates.pwr;
    end

    AST_MODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mode_oh) == 1); // R11
    AST_STOP2_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_oh[6] && !resume_q) |-> (!pwr_sw_on && !cpu_clk_en && !per_clk_en && !dbg_clk_en)); // R4
    AST_STOP3_LOOSE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_oh[5] && !resume_q) |-> (reg_loose && !cpu_clk_en && !per_clk_en)); // R5
    AST_WAKE_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        resume_q |-> (cpu_clk_en && per_clk_en && pwr_sw_on && !mode_oh[0] && !mode_oh[1])); // R10
endmodule

// File: tb/pmode_ctrl_test.sv
`timescale 1ns/1ps
module pmode_ctrl_test;
    localparam logic [6:0] RUN = 7'd1, LPRUN = 7'd2, WT = 7'd4, LPWT = 7'd8,
                           S4 = 7'd16, S3 = 7'd32, S2 = 7'd64;

    logic clk = 1'b0, rst_n = 1'b0;
    logic stop_en = 0, ill_rst_dis = 0, dbg_en = 0, lvd_en = 0, lvd_stop_en = 0;
    logic lp_reg = 0, deep_req = 0, ppd_req = 0, stop_req = 0, wait_req = 0, wake = 0;
    logic [6:0] mode_oh;
    logic cpu_clk_en, per_clk_en, per_clk_slow, dbg_clk_en, reg_loose, pwr_sw_on, ill_reset, ill_exc;

    int total = 0, bad = 0;
    logic done = 1'b0;

    // reference model state
    logic [6:0] m_mode, m_origin;
    logic m_resume, m_hold, m_ir, m_ie;

    always #2 clk = ~clk;

    pmode_ctrl uut (
        .clk(clk), .rst_n(rst_n), .stop_en(stop_en), .ill_rst_dis(ill_rst_dis),
        .dbg_en(dbg_en), .lvd_en(lvd_en), .lvd_stop_en(lvd_stop_en), .lp_reg(lp_reg),
        .deep_req(deep_req), .ppd_req(ppd_req), .stop_req(stop_req), .wait_req(wait_req),
        .wake(wake), .mode_oh(mode_oh), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .per_clk_slow(per_clk_slow), .dbg_clk_en(dbg_clk_en), .reg_loose(reg_loose),
        .pwr_sw_on(pwr_sw_on), .ill_reset(ill_reset), .ill_exc(ill_exc)
    );

    // stop depth from the R3 rule
    function automatic logic [6:0] f_depth();
        if (dbg_en || (lvd_en && lvd_stop_en) || !deep_req) return S4;
        return ppd_req ? S2 : S3;
    endfunction

    // enables {cpu,per,slow,dbg,loose,pwr} from R1, R4-R8
    function automatic logic [5:0] f_gates(input logic [6:0] md, input logic h, input logic live);
        case (md)
            RUN:   return {1'b1, 1'b1, 1'b0, live, 1'b0, 1'b1};
            LPRUN: return {1'b1, 1'b1, 1'b1, live, 1'b1, 1'b1};
            WT:    return {h, 1'b1, 1'b0, h, 1'b0, 1'b1};
            LPWT:  return {1'b0, 1'b1, 1'b1, h, 1'b1, 1'b1};
            S4:    return {h, 1'b0, 1'b0, h, 1'b0, 1'b1};
            S3:    return {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
            default: return 6'b0;
        endcase
    endfunction

    function automatic string f_tag();
        if (m_resume) return "R10";
        if (m_ir || m_ie) return "R2";
        case (m_mode)
            RUN: return "R1"; LPRUN: return "R7"; WT, LPWT: return "R8";
            S4: return "R6"; S3: return "R5"; default: return "R4";
        endcase
    endfunction

    task automatic model_step();
        logic act;
        if (!rst_n) begin
            m_mode = RUN; m_origin = RUN; m_resume = 0; m_hold = 0; m_ir = 0; m_ie = 0;
            return;
        end
        m_ir = 0; m_ie = 0;
        act = (m_mode == RUN) || (m_mode == LPRUN);
        if (m_resume) begin
            m_mode = m_origin; m_resume = 0;
        end else if (act) begin
            if (stop_req) begin
                if (!stop_en) begin m_ir = !ill_rst_dis; m_ie = ill_rst_dis; end
                else begin m_origin = m_mode; m_hold = dbg_en; m_mode = f_depth(); end
            end else if (wait_req) begin
                m_origin = m_mode; m_hold = dbg_en; m_mode = (m_mode == RUN) ? WT : LPWT;
            end else if (m_mode == RUN && lp_reg && !lvd_en) m_mode = LPRUN;
            else if (m_mode == LPRUN && (!lp_reg || lvd_en)) m_mode = RUN;
        end else if (wake) m_resume = 1;
    endtask

    // one clock: model update at the edge, compare at the following falling edge
    task automatic tick(input string tag);
        logic [5:0] eg, ag;
        string t;
        @(posedge clk);
        model_step();
        @(negedge clk);
        eg = f_gates(m_resume ? m_origin : m_mode, m_hold, dbg_en);
        ag = {cpu_clk_en, per_clk_en, per_clk_slow, dbg_clk_en, reg_loose, pwr_sw_on};
        t = (tag == "") ? f_tag() : tag;
        total++;
        if (mode_oh !== m_mode || ag !== eg || ill_reset !== m_ir || ill_exc !== m_ie
            || $countones(mode_oh) != 1) begin
            bad++;
            $display("FAIL %s: mode=%b gates=%b ir=%b ie=%b expected mode=%b gates=%b ir=%b ie=%b",
                     t, mode_oh, ag, ill_reset, ill_exc, m_mode, eg, m_ir, m_ie);
        end
    endtask

    task automatic quiet();
        stop_req = 0; wait_req = 0; wake = 0;
    endtask

    task automatic go_run();
        quiet(); lp_reg = 0; lvd_en = 0;
        wake = 1; tick(""); wake = 0; tick(""); tick("");
    endtask

    // watchdog
    initial begin
        #(4 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        tick("R1"); tick("R1");
        rst_n = 1;
        tick("R1");                                   // R1 reset state
        // R2 illegal STOP both flavours
        stop_en = 0; ill_rst_dis = 0; stop_req = 1; tick("R2"); quiet(); tick("R2");
        ill_rst_dis = 1; stop_req = 1; tick("R2"); quiet(); tick("R2");
        // R3/R6 stop4 via debug, held through changes (R9)
        stop_en = 1; dbg_en = 1; deep_req = 1; ppd_req = 1; stop_req = 1; tick("R3");
        quiet(); dbg_en = 0; stop_req = 1; wait_req = 1; tick("R9"); quiet(); tick("R9");
        wake = 1; tick("R10"); wake = 0; tick("R10"); tick("R10");
        // R4 stop2
        stop_req = 1; tick("R4"); quiet(); tick("R4"); go_run();
        // R5 stop3
        ppd_req = 0; stop_req = 1; tick("R5"); quiet(); tick("R5"); go_run();
        // R3 stop4 via low-voltage detection in stop, and via no deep request
        lvd_en = 1; lvd_stop_en = 1; stop_req = 1; tick("R3"); go_run();
        lvd_stop_en = 0; deep_req = 0; stop_req = 1; tick("R3"); go_run();
        // R7 low-power run, R8 low-power wait, R10 return to low-power run
        lp_reg = 1; tick("R7"); tick("R7");
        wait_req = 1; tick("R8"); quiet(); tick("R8");
        wake = 1; tick("R10"); wake = 0; tick("R10"); tick("R7");
        lp_reg = 0; tick("R7"); wait_req = 1; dbg_en = 1; tick("R8"); quiet(); tick("R8");
        go_run();
        // random phase
        for (int i = 0; i < 4000; i++) begin
            stop_en     = ($urandom % 8) != 0;
            ill_rst_dis = $urandom % 2;
            dbg_en      = ($urandom % 4) == 0;
            lvd_en      = ($urandom % 4) == 0;
            lvd_stop_en = $urandom % 2;
            lp_reg      = ($urandom % 3) == 0;
            deep_req    = ($urandom % 4) != 0;
            ppd_req     = $urandom % 2;
            stop_req    = ($urandom % 10) == 0;
            wait_req    = ($urandom % 10) == 0;
            wake        = ($urandom % 6) == 0;
            tick("");
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule